// File: doc/BRIEF.md
# Serial Control Port with Inverted Output Latches

This block is the register-side front end of a tuning controller. A host frames each exchange by raising a chip-enable line and then toggles a serial clock. Bits on the data input are taken on rising serial-clock edges. At the same time, a 28-bit status word moves out on the data output, most significant bit first, one bit per falling serial-clock edge. The outgoing word is captured when chip enable rises. Its top two bits are the two general input pins. The lower 26 bits come from a neighbouring measurement counter through a parallel port.

The last eight bits received in a transfer form a command byte: a time-base select flag followed by seven output-port bits. When chip enable falls, the byte is copied into holding latches, but only if at least eight bits arrived. The seven output pins show the latched bits inverted, with three exceptions. Pin 0 can be switched to an 8 Hz square wave. Pin 2 always drives the opposite level of pin 1. The open-drain pins (0 and 3 to 6) are also exported as active-low pull-down enables.

The block also divides the crystal clock to give a free-running controller clock: a 2:1 high-to-low waveform at one eighteenth of the crystal rate. All serial inputs are sampled by the crystal clock, which must be fast enough that each level lasts at least two of its cycles.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset, the latched command is all zero. The pin levels out_lvl[6:0] are 7'b1111011, od_pull_n is 5'b11111 and sdo is 0.
- R2: While ce is high, each rising sclk edge shifts sdi into the receiver. The command byte is the last eight bits received: the first of them is the time-base flag, then O6 down to O0, with O0 last.
- R3: A transfer with fewer than eight bits leaves the latched command unchanged. sclk edges while ce is low are not counted as bits.
- R4: With the time-base flag at 0, out_lvl[k] equals the inverse of latched bit Ok for k = 0, 1, 3, 4, 5 and 6.
- R5: out_lvl[2] is always the inverse of out_lvl[1]. Latched bit O2 has no effect on any pin.
- R6: With the time-base flag at 1, out_lvl[0] carries the time-base square wave instead of the inverse of O0. When the flag returns to 0, pin 0 follows the inverse of O0 again.
- R7: On a rising ce edge, the word {in_pins[1], in_pins[0], status_word[25:0]} is captured. sdo then shows bit 27, and each falling sclk edge with ce high advances sdo to the next lower bit.
- R8: sdo is 0 whenever ce is low.
- R9: ctl_clk has a period of CK_DIV crystal cycles (default 18). It is high for the first CK_HI cycles (default 12) and low for the rest, starting high at reset release.
- R10: The time base has a period of TB_DIV crystal cycles (default 900000, giving 8 Hz at 7.2 MHz): high for the first half, low for the second.
- R11: od_pull_n is {out_lvl[6:3], out_lvl[0]}; a 0 means that pin is pulling low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable framing a transfer |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| in_pins | input | 2 | General input pins sampled into the status word |
| status_word | input | 26 | Parallel counter readout loaded into the low status bits |
| sdo | output | 1 | Serial status data out |
| out_lvl | output | 7 | Logic level of each output-port pin |
| od_pull_n | output | 5 | Active-low pull-down enables for pins 6,5,4,3,0 |
| ctl_clk | output | 1 | Divided controller clock |

## Verification
The assertions assume that ce, sclk and sdi are synchronous to clk and that each level lasts at least two crystal cycles. Under that assumption, every serial edge is seen as exactly one rising or falling event. They also assume ce changes only while sclk is low, so a frame boundary never coincides with a shift. The bench drives every serial input at the falling clk edge, holds each level for two or more cycles, and raises or lowers ce only with sclk low.

// File: rtl/scp_pkg.sv
package scp_pkg;

  parameter int RX_W   = 8;
  parameter int TX_W   = 28;
  parameter int IN_W   = 2;
  parameter int N_PIN  = 7;
  parameter int N_OD   = 5;
  localparam int STAT_W = TX_W - IN_W;

  // Command byte layout: [RX_W-1] time-base select, [N_PIN-1:0] output-port bits.
  localparam int TB_BIT = RX_W - 1;

  // Pin levels from the latched command: inverted bits, pin 0 optionally the
  // time base, pin 2 the complement of pin 1 (bit 2 of the command unused).
  function automatic logic [N_PIN-1:0] pin_levels(input logic [RX_W-1:0] cmd,
                                                  input logic tick);
    logic [N_PIN-1:0] lv;
    lv      = ~cmd[N_PIN-1:0];
    lv[0]   = cmd[TB_BIT] ? tick : ~cmd[0];
    lv[2]   = cmd[1];
    return lv;
  endfunction

  // Open-drain pins 6..3 and 0: low level means the pull-down is on.
  function automatic logic [N_OD-1:0] od_view(input logic [N_PIN-1:0] lv);
    return {lv[6:3], lv[0]};
  endfunction

endpackage

// File: rtl/scp_divider.sv
module scp_divider #(
  parameter int DIV = 18,
  parameter int HI  = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic lvl
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HIGH = CW'(HI);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign lvl = (cnt < HIGH);

  // R9/R10: the level falls only after exactly HI high cycles
  p_fall_point_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl) |-> ($past(cnt) == HIGH - 1'b1));

  // R9/R10: the level rises only at the start of a new period
  p_rise_point_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl) |-> (cnt == '0 && $past(cnt) == LAST));
endmodule

// File: rtl/scp_rx.sv
module scp_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         shift,
  input  logic         sdi,
  input  logic         commit,
  output logic [W-1:0] cmd_q
);
  localparam int NW = $clog2(W + 1);
  localparam logic [NW-1:0] FULL = NW'(W);

  logic [W-1:0]  sr;
  logic [NW-1:0] nbits;
  logic          enough;

  assign enough = (nbits == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      nbits <= '0;
    end else begin
      if (start) nbits <= '0;
      else if (shift && !enough) nbits <= nbits + 1'b1;
      if (shift) sr <= {sr[W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cmd_q <= '0;
    else if (commit && enough) cmd_q <= sr;
  end

  // R2: a received bit enters at the bottom of the shift register
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (sr[0] == $past(sdi)));

  // R3: the latches move only at a frame end
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cmd_q));

  // R3: a short frame leaves the latches alone
  p_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && nbits < FULL) |=> $stable(cmd_q));
endmodule

// File: rtl/scp_tx.sv
module scp_tx #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];

  // R7: capture takes the whole parallel word
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (msb == $past(load_val[W-1])));

  // R7: each shift promotes the next lower bit
  p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (msb == $past(sr[W-2])));
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port #(
  parameter int CK_DIV = 18,
  parameter int CK_HI  = 12,
  parameter int TB_DIV = 900000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic [scp_pkg::IN_W-1:0]  in_pins,
  input  logic [scp_pkg::STAT_W-1:0] status_word,
  output logic                      sdo,
  output logic [scp_pkg::N_PIN-1:0] out_lvl,
  output logic [scp_pkg::N_OD-1:0]  od_pull_n,
  output logic                      ctl_clk
);
  import scp_pkg::*;

  localparam int TB_HI = TB_DIV / 2;

  logic ce_q, sclk_q;
  logic ce_rise, ce_fall, sclk_rise, sclk_fall;
  logic tx_msb, tick;
  logic [RX_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      ce_q   <= ce;
      sclk_q <= sclk;
    end
  end

  // Named frame and bit events
  assign ce_rise   = ce & ~ce_q;
  assign ce_fall   = ~ce & ce_q;
  assign sclk_rise = ce & sclk & ~sclk_q;
  assign sclk_fall = ce & ~sclk & sclk_q;

  scp_rx #(.W(RX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(ce_rise), .shift(sclk_rise),
    .sdi(sdi), .commit(ce_fall), .cmd_q(cmd_q)
  );

  scp_tx #(.W(TX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(ce_rise), .shift(sclk_fall),
    .load_val({in_pins, status_word}), .msb(tx_msb)
  );

  scp_divider #(.DIV(CK_DIV), .HI(CK_HI)) u_ckdiv (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_clk)
  );

  scp_divider #(.DIV(TB_DIV), .HI(TB_HI)) u_tbdiv (
    .clk(clk), .rst_n(rst_n), .lvl(tick)
  );

  assign sdo       = ce & tx_msb;
  assign out_lvl   = pin_levels(cmd_q, tick);
  assign od_pull_n = od_view(out_lvl);

  // R8: no data leaves outside a frame
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |-> !sdo);

  // R5: the push-pull pair never agrees
  p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_lvl[2] != out_lvl[1]);

  // R4/R6: pins other than 0 never follow the time base
  p_pins_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(out_lvl[N_PIN-1:1]));
endmodule

// File: tb/tb_serial_ctrl_port.sv
module tb_serial_ctrl_port;
  localparam int TBD = 40;

  logic clk = 0, rst_n = 0, ce = 0, sclk = 0, sdi = 0;
  logic [1:0]  in_pins = 0;
  logic [25:0] status_word = 0;
  logic sdo, ctl_clk;
  logic [6:0] out_lvl;
  logic [4:0] od_pull_n;

  int checks = 0, errors = 0;
  logic [6:0] cur_o = 0;

  serial_ctrl_port #(.TB_DIV(TBD)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
    .in_pins(in_pins), .status_word(status_word), .sdo(sdo),
    .out_lvl(out_lvl), .od_pull_n(od_pull_n), .ctl_clk(ctl_clk)
  );

  always #2.5 clk = ~clk;

  // {tb flag, O6..O0, in1 in0, status}
  localparam logic [35:0] VEC [6] = '{
    {1'b0, 7'h00, 2'b00, 26'h0000000},
    {1'b0, 7'h55, 2'b10, 26'h2A55A5A},
    {1'b0, 7'h7F, 2'b11, 26'h3FFFFFF},
    {1'b0, 7'h2A, 2'b01, 26'h1234567},
    {1'b0, 7'h04, 2'b10, 26'h0000001},
    {1'b0, 7'h13, 2'b00, 26'h3C3C3C3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected pins: inverted, pin 2 = complement of pin 1
  function automatic logic [6:0] want_pins(input logic [6:0] o);
    logic [6:0] e;
    for (int k = 0; k < 7; k++) e[k] = !o[k];
    e[2] = o[1];
    return e;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [27:0] mosi, input int nb,
                      input logic [27:0] miso, input bit do_chk);
    ce = 1; sclk = 0;
    step(3);
    for (int i = 0; i < nb; i++) begin
      sdi = mosi[nb-1-i];
      step(2);
      if (do_chk) chk("R7 sdo bit", 32'(sdo), 32'(miso[27-i]));
      sclk = 1; step(2);
      sclk = 0; step(2);
    end
    ce = 0; sdi = 0;
    step(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] e;
    int hi, lo, g;
    step(3);
    rst_n = 1;
    // R9: controller clock phase from reset release (sampled right after)
    for (int k = 0; k < 36; k++) begin
      chk("R9 ctl_clk", 32'(ctl_clk), 32'((k % 18) < 12));
      step(1);
    end
    // R1 reset state
    chk("R1 pins", 32'(out_lvl), 32'h7B);
    chk("R1 od_pull_n", 32'(od_pull_n), 32'h1F);
    chk("R1 sdo", 32'(sdo), 0);

    // Table walk: R2 R4 R5 R7 R8 R11
    for (int v = 0; v < 6; v++) begin
      in_pins     = VEC[v][27:26];
      status_word = VEC[v][25:0];
      xfer({20'h0, VEC[v][35:28]}, 28, VEC[v][27:0], 1);
      cur_o = VEC[v][34:28];
      e = want_pins(cur_o);
      chk("R2 R4 R5 pins", 32'(out_lvl), 32'(e));
      chk("R11 od_pull_n", 32'(od_pull_n), 32'({e[6:3], e[0]}));
      chk("R8 sdo idle", 32'(sdo), 0);
    end

    // R3: short frame of five ones
    xfer(28'h1F, 5, 28'h0, 0);
    chk("R3 short frame", 32'(out_lvl), 32'(want_pins(cur_o)));
    // R3: sclk with ce low, then an empty frame
    sdi = 1;
    for (int i = 0; i < 8; i++) begin sclk = 1; step(2); sclk = 0; step(2); end
    ce = 1; step(3); ce = 0; step(3);
    chk("R3 ce low ignored", 32'(out_lvl), 32'(want_pins(cur_o)));
    chk("R8 sdo low", 32'(sdo), 0);

    // R2: 8-bit write frame only
    xfer(28'h02, 8, 28'h0, 0);
    cur_o = 7'h02;
    chk("R2 eight-bit frame", 32'(out_lvl), 32'(want_pins(cur_o)));

    // R6 R10: time base on pin 0
    xfer(28'h80, 8, 28'h0, 0);
    chk("R6 other pins", 32'(out_lvl[6:1]), 32'(want_pins(7'h00) >> 1));
    g = 0;
    while (out_lvl[0] !== 1'b0 && g < 200) begin step(1); g++; end
    while (out_lvl[0] !== 1'b1 && g < 200) begin step(1); g++; end
    hi = 0;
    while (out_lvl[0] === 1'b1 && hi < 200) begin step(1); hi++; end
    lo = 0;
    while (out_lvl[0] === 1'b0 && lo < 200) begin step(1); lo++; end
    chk("R10 time base high", 32'(hi), TBD / 2);
    chk("R10 time base low", 32'(lo), TBD / 2);
    chk("R11 od follows tick", 32'(od_pull_n[0]), 32'(out_lvl[0]));

    // R6: back to latched bit, O0 = 1 gives a steady low
    xfer(28'h01, 8, 28'h0, 0);
    hi = 0;
    for (int i = 0; i < 60; i++) begin
      if (out_lvl[0] !== 1'b0) hi++;
      step(1);
    end
    chk("R6 pin0 steady after flag clear", 32'(hi), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule